// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous request port and a 2048 x 8 asynchronous static RAM. A single-cycle request carries a direction, an 11-bit address and, for writes, a byte. The controller turns it into the RAM's active-low chip-select, write-strobe and output-gate signals. It drives the address and splits the bidirectional data pins into separate outgoing, incoming and drive-enable signals. Read data returns on `rdata`, marked by a one-cycle `rvalid` pulse. Every request ends with a one-cycle `done` pulse.

All interface timing is given in nanoseconds through parameters. The controller turns each figure into whole clock counts by rounding up: `ceil(ns / CLK_NS)`, and a zero figure gives zero cycles. A single sequencer with one down-counter enforces those counts.

A write is the interval in which chip-select and write-strobe are both low. Which of the two strobes ends that interval is chosen at build time, and the hold and recovery figures that belong to that edge are applied.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with the address latched. `mem_dq_in` is captured ACC+1 clocks after the strobes fall, where ACC = max of ceil(ns/CLK_NS) over the address, chip-select and output-gate access times (13 at defaults). The captured byte appears on `rdata` with exactly one `rvalid` pulse.
- R2: A write holds `mem_ce_n` and `mem_we_n` both low for P = max(ceil(pulse width), ceil(data setup)) clocks (10 at defaults). `mem_oe_n` stays high throughout, and the address does not change.
- R3: The controller never drives `mem_dq_out` (`mem_dq_oe`=1) while `mem_oe_n` is low.
- R4: With `CLOSE_ON_CE`=0, `mem_we_n` rises first and `mem_ce_n` stays low for H = max(1, ceil(hold after write-strobe edge)) clocks. With `CLOSE_ON_CE`=1, `mem_ce_n` rises first and `mem_we_n` stays low for H = max(1, ceil(hold after chip-select edge)) clocks. The data drive lasts through the write and through those H clocks, and is released in the same cycle that both strobes are high.
- R5: `mem_addr` does not change while `mem_ce_n` stays low.
- R6: `done` pulses for one clock. For a write it comes P+H+R clocks after the accepting edge, where R = max(1, ceil(recovery for the closing edge), WC-P-H). For a read it comes ACC+1+max(1, RC-ACC-1) clocks after that edge. WC and RC are the write and read cycle times in clocks.
- R7: A request is accepted only while idle. `busy` is high from the clock after acceptance until `done`. A request raised while `busy` is high has no effect: no strobe activity, no memory change and no extra `done`.
- R8: After reset, and whenever `busy` is low, all strobes are high and the data drive is off. After reset `done` and `rvalid` are low.
- R9: Each interval count is ceil(ns/CLK_NS), and a zero interval gives 0 clocks. At CLK_NS=8 the defaults give write latency 13 (write-strobe close) or 14 (chip-select close) and read latency 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read byte |
| rvalid | output | 1 | One-cycle pulse marking `rdata` |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip-select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_dq_out | output | DATA_W | Byte driven onto the RAM data pins |
| mem_dq_in | input | DATA_W | Byte read from the RAM data pins |
| mem_dq_oe | output | 1 | Enable for the controller's data drive |

## Verification
The bench builds two copies at the default 11-bit address, 8-bit data and 8 ns clock. One copy has `CLOSE_ON_CE`=0 and the other `CLOSE_ON_CE`=1, so both hold/recovery branches run side by side: a 1-clock hold with write-strobe close and a 2-clock hold with chip-select close. With 2048 locations, every address can be written and then read back. Each copy has its own memory model, which returns the complement of the stored byte until the strobes have been low for ACC clocks, so an early capture shows up as a data mismatch. The model also measures each write's pulse, hold and closing edge.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STRB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    localparam strobe_t STRB_READ = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
    localparam strobe_t STRB_WRITE = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};

    // Round a nanosecond interval up to whole clocks; zero stays zero.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned ACC_CYC     = 13,
    parameter int unsigned RD_REC_CYC  = 1,
    parameter int unsigned PULSE_CYC   = 10,
    parameter int unsigned HOLD_CYC    = 1,
    parameter int unsigned WR_REC_CYC  = 2,
    parameter bit          CLOSE_ON_CE = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    req_wr,
    output logic    accept,
    output logic    capture,
    output logic    busy,
    output logic    done,
    output strobe_t strb
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    strobe_t          strb_d;
    strobe_t          hold_strb;

    // Strobe pattern for the hold phase: the closing strobe is already high.
    generate
        if (CLOSE_ON_CE) begin : g_close_ce
            assign hold_strb = '{ce_n: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
        end else begin : g_close_we
            assign hold_strb = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_wr) begin
                        state_d = ST_WR_PULSE;
                        cnt_d   = CNT_W'(PULSE_CYC - 1);
                    end else begin
                        state_d = ST_RD_ACC;
                        cnt_d   = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_q == '0) state_d = ST_RD_CAP;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_RD_CAP: begin
                capture = 1'b1;
                state_d = ST_RECOVER;
                cnt_d   = CNT_W'(RD_REC_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_HOLD;
                    cnt_d   = CNT_W'(HOLD_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(WR_REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobes are registered from the next state so they switch with it.
    always_comb begin
        case (state_d)
            ST_RD_ACC, ST_RD_CAP: strb_d = STRB_READ;
            ST_WR_PULSE:          strb_d = STRB_WRITE;
            ST_WR_HOLD:           strb_d = hold_strb;
            default:              strb_d = STRB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            strb    <= STRB_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            strb    <= strb_d;
            done    <= (state_q == ST_RECOVER) && (cnt_q == '0);
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
module sram_req_latch #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_NS      = 8,
    parameter int unsigned T_AA_NS     = 100,
    parameter int unsigned T_CEA_NS    = 100,
    parameter int unsigned T_OEA_NS    = 50,
    parameter int unsigned T_RC_NS     = 100,
    parameter int unsigned T_WP_NS     = 75,
    parameter int unsigned T_DS_NS     = 40,
    parameter int unsigned T_WC_NS     = 100,
    parameter int unsigned T_DH_WE_NS  = 0,
    parameter int unsigned T_DH_CE_NS  = 10,
    parameter int unsigned T_WR_WE_NS  = 0,
    parameter int unsigned T_WR_CE_NS  = 10,
    parameter bit          CLOSE_ON_CE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int unsigned ACC_CYC = umax(1, umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                      umax(ns_to_cyc(T_CEA_NS, CLK_NS), ns_to_cyc(T_OEA_NS, CLK_NS))));
    localparam int unsigned RC_CYC     = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned RD_REC_CYC = umax(1, (RC_CYC > ACC_CYC + 1) ? RC_CYC - ACC_CYC - 1 : 0);
    localparam int unsigned PULSE_CYC  = umax(1, umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)));
    localparam int unsigned DH_NS      = CLOSE_ON_CE ? T_DH_CE_NS : T_DH_WE_NS;
    localparam int unsigned WREC_NS    = CLOSE_ON_CE ? T_WR_CE_NS : T_WR_WE_NS;
    localparam int unsigned HOLD_CYC   = umax(1, ns_to_cyc(DH_NS, CLK_NS));
    localparam int unsigned WC_CYC     = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WR_REC_CYC = umax(1, umax(ns_to_cyc(WREC_NS, CLK_NS),
                                      (WC_CYC > PULSE_CYC + HOLD_CYC) ? WC_CYC - PULSE_CYC - HOLD_CYC : 0));
    localparam int unsigned MAX_CYC    = umax(umax(ACC_CYC, RD_REC_CYC),
                                      umax(PULSE_CYC, umax(HOLD_CYC, WR_REC_CYC)));
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    logic    accept;
    logic    capture;
    strobe_t strb;

    sram_seq_fsm #(
        .CNT_W       (CNT_W),
        .ACC_CYC     (ACC_CYC),
        .RD_REC_CYC  (RD_REC_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .WR_REC_CYC  (WR_REC_CYC),
        .CLOSE_ON_CE (CLOSE_ON_CE)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_wr  (req_wr),
        .accept  (accept),
        .capture (capture),
        .busy    (busy),
        .done    (done),
        .strb    (strb)
    );

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_latch (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) i_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .dq_in   (mem_dq_in),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    assign mem_ce_n  = strb.ce_n;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_dq_oe = strb.drive;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    a_r1_rvalid_single: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    a_r2_gate_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    a_r4_window_driven: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !mem_we_n) |-> mem_dq_oe);

    a_r4_release_after_close: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> (mem_ce_n && mem_we_n));

    a_r5_addr_held: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .rvalid    (rvalid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_model.sv
`timescale 1ns/1ps
module sram_bus_model #(
    parameter int ACC_CYC   = 13,
    parameter int PULSE_CYC = 10,
    parameter int HOLD_CYC  = 1,
    parameter bit CLOSE_CE  = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] addr,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  dq_w,
    input  logic        dq_oe,
    output logic [7:0]  dq_r,
    output int          checks,
    output int          fails
);

    logic [7:0]  mem [0:2047];
    int          rd_cnt;
    int          win_cnt;
    int          hold_cnt;
    bit          win_q;
    bit          in_hold;
    bit          bad_gate;
    bit          bad_addr;
    bit          other_rose;
    logic [10:0] win_addr;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        checks = 0;
        fails  = 0;
    end

    // Data is wrong (complemented) until the read strobes have been low ACC_CYC clocks.
    always_comb dq_r = (rd_cnt >= ACC_CYC) ? mem[addr] : ~mem[addr];

    task automatic note(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (close_ce=%0d) actual=%0d expected=%0d", tag, CLOSE_CE, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            rd_cnt  <= 0;
            win_q   = 1'b0;
            in_hold = 1'b0;
        end else begin
            rd_cnt <= (!ce_n && !oe_n && we_n) ? rd_cnt + 1 : 0;
            if (in_hold) begin
                if (dq_oe) begin
                    hold_cnt++;
                    if (CLOSE_CE ? we_n : ce_n) other_rose = 1'b1;
                end else begin
                    in_hold = 1'b0;
                    note(hold_cnt == HOLD_CYC, "R4 hold clocks", hold_cnt, HOLD_CYC);
                    note(!other_rose && ce_n && we_n, "R4 second strobe released with drive",
                         int'(other_rose), 0);
                end
            end
            if (!ce_n && !we_n) begin
                if (!win_q) begin
                    win_addr = addr;
                    win_cnt  = 1;
                    bad_gate = !oe_n;
                    bad_addr = 1'b0;
                end else begin
                    win_cnt++;
                    if (!oe_n) bad_gate = 1'b1;
                    if (addr != win_addr) bad_addr = 1'b1;
                end
                if (!dq_oe) bad_gate = 1'b1;
                win_q = 1'b1;
            end else if (win_q) begin
                win_q = 1'b0;
                mem[win_addr] <= dq_w;
                note(win_cnt == PULSE_CYC, "R2 write window clocks", win_cnt, PULSE_CYC);
                note(!bad_gate, "R2 gate high and data driven in window", int'(bad_gate), 0);
                note(!bad_addr && addr == win_addr, "R5 address held in window", int'(addr), int'(win_addr));
                note(dq_oe, "R4 data driven at closing edge", int'(dq_oe), 1);
                if (CLOSE_CE)
                    note(ce_n && !we_n, "R4 chip-select closes write", int'({ce_n, we_n}), 2);
                else
                    note(we_n && !ce_n, "R4 write-strobe closes write", int'({ce_n, we_n}), 1);
                in_hold    = 1'b1;
                hold_cnt   = 1;
                other_rose = 1'b0;
            end
        end
    end

endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

    localparam int CLK_NS = 8;

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts from R1, R2, R4, R6, R9 at default timing.
    localparam int EXP_ACC   = imax(cdiv(100), imax(cdiv(100), cdiv(50)));
    localparam int EXP_PULSE = imax(cdiv(75), cdiv(40));
    localparam int EXP_H0    = imax(1, cdiv(0));
    localparam int EXP_H1    = imax(1, cdiv(10));
    localparam int EXP_REC0  = imax(1, imax(cdiv(0), cdiv(100) - EXP_PULSE - EXP_H0));
    localparam int EXP_REC1  = imax(1, imax(cdiv(10), cdiv(100) - EXP_PULSE - EXP_H1));
    localparam int EXP_RDLAT = EXP_ACC + 1 + imax(1, cdiv(100) - EXP_ACC - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;

    logic        busy_w   [2];
    logic        done_w   [2];
    logic [7:0]  rdata_w  [2];
    logic        rvalid_w [2];
    logic [10:0] addr_w   [2];
    logic        ce_n_w   [2];
    logic        we_n_w   [2];
    logic        oe_n_w   [2];
    logic [7:0]  dqo_w    [2];
    logic [7:0]  dqi_w    [2];
    logic        dqoe_w   [2];
    int          mchk     [2];
    int          mfail    [2];

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    for (genvar g = 0; g < 2; g++) begin : g_dut
        sram_strobe_ctrl #(.CLK_NS(CLK_NS), .CLOSE_ON_CE(g == 1)) i_sram_strobe_ctrl (
            .clk        (clk),
            .rst        (rst),
            .req        (req),
            .req_wr     (req_wr),
            .req_addr   (req_addr),
            .req_wdata  (req_wdata),
            .busy       (busy_w[g]),
            .done       (done_w[g]),
            .rdata      (rdata_w[g]),
            .rvalid     (rvalid_w[g]),
            .mem_addr   (addr_w[g]),
            .mem_ce_n   (ce_n_w[g]),
            .mem_we_n   (we_n_w[g]),
            .mem_oe_n   (oe_n_w[g]),
            .mem_dq_out (dqo_w[g]),
            .mem_dq_in  (dqi_w[g]),
            .mem_dq_oe  (dqoe_w[g])
        );
        sram_bus_model #(
            .ACC_CYC   (EXP_ACC),
            .PULSE_CYC (EXP_PULSE),
            .HOLD_CYC  ((g == 1) ? EXP_H1 : EXP_H0),
            .CLOSE_CE  (g == 1)
        ) i_model (
            .clk    (clk),
            .rst    (rst),
            .addr   (addr_w[g]),
            .ce_n   (ce_n_w[g]),
            .we_n   (we_n_w[g]),
            .oe_n   (oe_n_w[g]),
            .dq_w   (dqo_w[g]),
            .dq_oe  (dqoe_w[g]),
            .dq_r   (dqi_w[g]),
            .checks (mchk[g]),
            .fails  (mfail[g])
        );
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    task automatic expect_eq(input string tag, input int g, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s inst=%0d actual=%0d expected=%0d", tag, g, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + mchk[0] + mchk[1], n_fail + mfail[0] + mfail[1]);
        $finish;
    endtask

    // One request issued to both copies; optional second request raised while busy.
    task automatic xact(input logic wr, input int a, input logic [7:0] d, input bit inject);
        int         n;
        logic [1:0] got;
        int         lat [2];
        int         vcnt [2];
        int         vcyc [2];
        logic [7:0] rd [2];
        @(negedge clk);
        while (busy_w[0] || busy_w[1]) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = 11'(a); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        n = 0; got = '0;
        for (int g = 0; g < 2; g++) begin lat[g] = 0; vcnt[g] = 0; vcyc[g] = 0; rd[g] = '0; end
        while (got != 2'b11 && n < 60) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 3) begin
                req = 1'b1; req_wr = 1'b1; req_addr = 11'(a) ^ 11'h1; req_wdata = ~d;
            end else begin
                req = 1'b0;
            end
            for (int g = 0; g < 2; g++) begin
                if (n == 1) expect_eq("R7 busy after accept", g, int'(busy_w[g]), 1);
                if (rvalid_w[g]) begin vcnt[g]++; vcyc[g] = n; rd[g] = rdata_w[g]; end
                if (done_w[g] && !got[g]) begin got[g] = 1'b1; lat[g] = n; end
            end
        end
        req = 1'b0;
        for (int g = 0; g < 2; g++) begin
            if (wr) expect_eq("R6 R9 write latency", g, lat[g],
                              (g == 1) ? EXP_PULSE + EXP_H1 + EXP_REC1 : EXP_PULSE + EXP_H0 + EXP_REC0);
            else begin
                expect_eq("R6 R9 read latency", g, lat[g], EXP_RDLAT);
                expect_eq("R1 single rvalid", g, vcnt[g], 1);
                expect_eq("R1 capture clock", g, vcyc[g], EXP_ACC + 1);
                expect_eq("R1 read data", g, int'(rd[g]), int'(d));
            end
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            // R8: quiet bus after reset
            expect_eq("R8 reset strobes", g, int'({ce_n_w[g], we_n_w[g], oe_n_w[g], dqoe_w[g]}), 4'b1110);
            expect_eq("R8 reset flags", g, int'({busy_w[g], done_w[g], rvalid_w[g]}), 0);
        end

        // Write every location, then a write with an intruding request, then read all back.
        for (int a = 0; a < 2048; a++) xact(1'b1, a, pat(a), 1'b0);

        xact(1'b1, 5, 8'h11, 1'b1);
        begin
            int idle_bad = 0;
            repeat (30) begin
                @(negedge clk);
                for (int g = 0; g < 2; g++)
                    if (done_w[g] || !ce_n_w[g] || busy_w[g]) idle_bad++;
            end
            expect_eq("R7 request during busy ignored", 0, idle_bad, 0);
        end

        for (int a = 0; a < 2048; a++) xact(1'b0, a, (a == 5) ? 8'h11 : pat(a), 1'b0);

        finish_report();
    end

endmodule